// File: doc/BRIEF.md
# BCH Syndrome Calculator over GF(32)

This block computes the six syndromes of a 31-bit received word for a binary BCH code that corrects up to three errors. The word arrives one bit per valid cycle, highest coefficient first, after a start pulse. Three polynomial dividers run in parallel while the word streams in, one for each distinct minimal polynomial. Each divider leaves a 5-bit remainder.

Once the last bit is in, one field reducer turns the remainders into field elements, one syndrome after another. For syndrome i, it streams the bits of the matching remainder with i-1 zero bits placed between neighbouring bits, and it reduces that stream modulo the field polynomial. A one-cycle done pulse marks the point where all six values are valid. Each value is a GF(32) element, where bit k holds the coefficient of alpha^k. A decoder that follows this block treats six zero syndromes as an error-free word.

Top module: `bch_syndrome_calc`

## Requirements
- R1: While reset is asserted and after it is released, `synd_o` is all zero and `done_o` is low.
- R2: A cycle with `start_i` high clears all syndrome outputs, so they read zero in the next cycle. It also abandons any word that is being collected or evaluated. The next 31 accepted bits form a new word.
- R3: After a start, a bit is accepted only in a cycle where `valid_i` is high. The first accepted bit is the coefficient of x^30 and the 31st is the coefficient of x^0. Cycles with `valid_i` low have no effect on the result.
- R4: Syndrome Si equals r(alpha^i) for i = 1..6. Here r(x) is the received polynomial and alpha is a root of the field polynomial x^5+x^2+1. Si appears on `synd_o[5*(i-1)+4 : 5*(i-1)]`.
- R5: Any multiple of the code generator yields six zero syndromes. The generator is the product of x^5+x^2+1, x^5+x^4+x^3+x^2+1 and x^5+x^4+x^2+x+1.
- R6: For any word, S2 = S1^2, S4 = S2^2 and S6 = S3^2 in the field. A single error at position j gives S1 = alpha^j.
- R7: `done_o` is high for exactly one cycle. This happens 91 clock cycles after the cycle that accepts the 31st bit.
- R8: After `done_o`, the syndrome outputs hold their values until the next start, whatever `valid_i` and `bit_i` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new word and clears the outputs |
| valid_i | input | 1 | Marks `bit_i` as a word bit |
| bit_i | input | 1 | Serial received bit, highest coefficient first |
| done_o | output | 1 | One-cycle pulse when all syndromes are valid |
| synd_o | output | 30 | Six 5-bit syndromes, S1 in the low bits |

## Verification
The bench compares each result with direct Horner evaluation of r(alpha^i), which is a different path from the divide-then-spread method in the design. The input words are chosen to separate specific faults:
- The all-zero and all-one words and several irregular patterns expose a wrong tap in any of the three dividers or in the reducer.
- Single-bit words at the two ends and in the middle expose faults in bit order and spreading.
- Generator multiples must give all zeros, which exposes a mismatch between the dividers and the reducer.
- A word sent with idle gaps, plus starts issued during collection and during evaluation, confirm that only accepted bits of the current word count.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;
  localparam int unsigned GF_M  = 5;
  localparam int unsigned N_DIV = 3;

  typedef logic [GF_M-1:0] gf_t;

  // low terms of the monic field polynomial x^5+x^2+1
  localparam gf_t FIELD_TAPS = 5'b00101;

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_EVAL} st_e;

  function automatic gf_t div_taps(int unsigned d);
    case (d)
      0:       return 5'b00101;  // x^5+x^2+1
      1:       return 5'b11101;  // x^5+x^4+x^3+x^2+1
      default: return 5'b10111;  // x^5+x^4+x^2+x+1
    endcase
  endfunction

  // divider holding the minimal polynomial of alpha^i (i is 1-based)
  function automatic int unsigned div_of_syn(int unsigned i);
    case (i)
      1, 2, 4: return 0;
      3, 6:    return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/bch_lfsr_div.sv
module bch_lfsr_div #(
  parameter int unsigned   W    = 5,
  parameter logic [W-1:0]  TAPS = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,   // restart from zero (merged with a shift when en_i)
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] base, nxt;

  always_comb begin
    base = clr_i ? '0 : rem_o;
    nxt  = {base[W-2:0], bit_i} ^ (base[W-1] ? TAPS : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rem_o <= '0;
    else if (en_i)  rem_o <= nxt;
    else if (clr_i) rem_o <= '0;
  end
endmodule

// File: rtl/bch_spread_seq.sv
module bch_spread_seq
  import bch_syn_pkg::*;
#(
  parameter int unsigned NSYN = 6,
  localparam int unsigned W  = GF_M,
  localparam int unsigned IW = $clog2(NSYN + 1),
  localparam int unsigned KW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          abort_i,
  input  gf_t           rems_i [N_DIV],
  output logic          active_o,
  output logic          first_o,
  output logic          syn_end_o,
  output logic          bit_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] idx_q, z_q;
  logic [KW-1:0] k_q;
  gf_t           rem_sel;

  always_comb begin
    rem_sel   = rems_i[div_of_syn(int'(idx_q))];
    bit_o     = (z_q == '0) ? rem_sel[k_q] : 1'b0;
    first_o   = active_o && (k_q == KW'(W - 1)) && (z_q == '0);
    syn_end_o = active_o && (k_q == '0) && (z_q == '0);
    idx_o     = idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      idx_q    <= IW'(1);
      k_q      <= KW'(W - 1);
      z_q      <= '0;
    end else if (abort_i) begin
      active_o <= 1'b0;
    end else if (go_i) begin
      active_o <= 1'b1;
      idx_q    <= IW'(1);
      k_q      <= KW'(W - 1);
      z_q      <= '0;
    end else if (active_o) begin
      if (syn_end_o) begin
        if (idx_q == IW'(NSYN)) active_o <= 1'b0;
        idx_q <= idx_q + IW'(1);
        k_q   <= KW'(W - 1);
        z_q   <= '0;
      end else if (z_q == idx_q - IW'(1)) begin
        z_q <= '0;
        k_q <= k_q - KW'(1);
      end else begin
        z_q <= z_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/bch_syndrome_calc.sv
module bch_syndrome_calc
  import bch_syn_pkg::*;
#(
  parameter int unsigned N_BITS = 31,
  parameter int unsigned NSYN   = 6,
  localparam int unsigned W  = GF_M,
  localparam int unsigned CW = $clog2(N_BITS),
  localparam int unsigned IW = $clog2(NSYN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            valid_i,
  input  logic            bit_i,
  output logic            done_o,
  output logic [NSYN*W-1:0] synd_o
);
  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          collect_en, last_bit;
  gf_t           div_rem [N_DIV];
  logic          seq_active, seq_first, seq_end, seq_bit;
  logic [IW-1:0] seq_idx, pend_idx_q;
  logic          pend_q;
  gf_t           eval_rem;
  gf_t           syn_q [NSYN];

  assign collect_en = (st_q == ST_COLLECT) && valid_i && !start_i;
  assign last_bit   = collect_en && (cnt_q == CW'(N_BITS - 1));

  for (genvar d = 0; d < N_DIV; d++) begin : g_div
    bch_lfsr_div #(.W(W), .TAPS(div_taps(d))) i_div (
      .clk_i, .rst_ni,
      .clr_i (start_i),
      .en_i  (collect_en),
      .bit_i (bit_i),
      .rem_o (div_rem[d])
    );
  end

  bch_spread_seq #(.NSYN(NSYN)) i_seq (
    .clk_i, .rst_ni,
    .go_i      (last_bit),
    .abort_i   (start_i),
    .rems_i    (div_rem),
    .active_o  (seq_active),
    .first_o   (seq_first),
    .syn_end_o (seq_end),
    .bit_o     (seq_bit),
    .idx_o     (seq_idx)
  );

  bch_lfsr_div #(.W(W), .TAPS(FIELD_TAPS)) i_reduce (
    .clk_i, .rst_ni,
    .clr_i (seq_first),
    .en_i  (seq_active),
    .bit_i (seq_bit),
    .rem_o (eval_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (start_i) begin
      st_q  <= ST_COLLECT;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_COLLECT: begin
          if (collect_en) cnt_q <= cnt_q + CW'(1);
          if (last_bit)   st_q  <= ST_EVAL;
        end
        ST_EVAL: if (pend_q && pend_idx_q == IW'(NSYN)) st_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  // write-back one cycle after each syndrome's final shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      done_o     <= 1'b0;
      for (int s = 0; s < NSYN; s++) syn_q[s] <= '0;
    end else if (start_i) begin
      pend_q <= 1'b0;
      done_o <= 1'b0;
      for (int s = 0; s < NSYN; s++) syn_q[s] <= '0;
    end else begin
      pend_q     <= seq_end;
      pend_idx_q <= seq_idx;
      done_o     <= pend_q && (pend_idx_q == IW'(NSYN));
      if (pend_q)
        for (int s = 0; s < NSYN; s++)
          if (pend_idx_q == IW'(s + 1)) syn_q[s] <= eval_rem;
    end
  end

  for (genvar s = 0; s < NSYN; s++) begin : g_out
    assign synd_o[s*W +: W] = syn_q[s];
  end
endmodule

// File: rtl/bch_syndrome_chk.sv
module bch_syndrome_chk
  import bch_syn_pkg::*;
#(
  parameter int unsigned NSYN = 6,
  localparam int unsigned W = GF_M
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            done_o,
  input logic [NSYN*W-1:0] synd_o,
  input st_e             st_q
);
  function automatic gf_t mul_a(gf_t a);
    return {a[W-2:0], 1'b0} ^ (a[W-1] ? FIELD_TAPS : '0);
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t p = '0;
    for (int i = W - 1; i >= 0; i--) p = mul_a(p) ^ (b[i] ? a : '0);
    return p;
  endfunction

  gf_t s1, s2, s3, s4, s6;
  assign s1 = synd_o[0*W +: W];
  assign s2 = synd_o[1*W +: W];
  assign s3 = synd_o[2*W +: W];
  assign s4 = synd_o[3*W +: W];
  assign s6 = synd_o[5*W +: W];

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(st_q) == ST_EVAL); // R7

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> synd_o == '0); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> $stable(synd_o)); // R8

  AST_CONJUGATE_SQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (s2 == gf_mul(s1, s1)) && (s4 == gf_mul(s2, s2)) && (s6 == gf_mul(s3, s3))); // R6
endmodule

bind bch_syndrome_calc bch_syndrome_chk #(.NSYN(NSYN)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .synd_o  (synd_o),
  .st_q    (st_q)
);

// File: tb/test_bch_syndrome_calc.sv
module test_bch_syndrome_calc;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, valid_i = 1'b0, bit_i = 1'b0;
  logic        done_o;
  logic [29:0] synd_o;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #10ns clk_i = ~clk_i;  // 50 MHz

  bch_syndrome_calc i_bch_syndrome_calc (.*);

  localparam logic [30:0] VEC [8] = '{31'h0000_0000, 31'h0000_0001, 31'h4000_0000, 31'h7FFF_FFFF,
                                      31'h1234_5678, 31'h2AAA_AAAA, 31'h0000_0100, 31'h6C3A_91E5};

  function automatic logic [4:0] mul_a(logic [4:0] a);
    return {a[3:0], 1'b0} ^ (a[4] ? 5'b00101 : 5'b0);
  endfunction

  function automatic logic [4:0] apow(int e);
    logic [4:0] x = 5'b00001;
    for (int i = 0; i < e % 31; i++) x = mul_a(x);
    return x;
  endfunction

  // direct Horner evaluation of r(alpha^i)
  function automatic logic [29:0] ref_synd(logic [30:0] w);
    logic [29:0] r = '0;
    for (int i = 1; i <= 6; i++) begin
      logic [4:0] s = '0;
      for (int j = 30; j >= 0; j--) begin
        for (int k = 0; k < i; k++) s = mul_a(s);
        s[0] = s[0] ^ w[j];
      end
      r[(i-1)*5 +: 5] = s;
    end
    return r;
  endfunction

  function automatic logic [30:0] pmul(logic [30:0] a, logic [30:0] b);
    logic [30:0] r = '0;
    for (int i = 0; i < 31; i++) if (b[i]) r = r ^ (a << i);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [30:0] w, input int nbits, input bit gaps);
    @(negedge clk_i); start_i = 1'b1; valid_i = 1'b0;
    @(negedge clk_i); start_i = 1'b0;
    for (int j = 30; j > 30 - nbits; j--) begin
      if (gaps && (j % 3 == 0)) begin
        valid_i = 1'b0; bit_i = ~w[j];
        @(negedge clk_i);
        @(negedge clk_i);
      end
      valid_i = 1'b1; bit_i = w[j];
      @(negedge clk_i);
    end
    valid_i = 1'b0;
  endtask

  task automatic run_word(input logic [30:0] w, input bit gaps, input string tag, output logic [29:0] res);
    int lat = 0;
    send_bits(w, 31, gaps);
    // at the negedge after the last accepted bit
    while (!done_o && lat < 200) begin
      @(negedge clk_i); lat++;
    end
    chk(lat == 91, {tag, " R7 latency"}, lat, 91);
    chk(synd_o == ref_synd(w), {tag, " R4 syndromes"}, {2'b0, synd_o}, {2'b0, ref_synd(w)});
    res = synd_o;
    @(negedge clk_i);
    chk(!done_o, {tag, " R7 single pulse"}, done_o, 0);
  endtask

  initial begin
    logic [29:0] res;
    logic [30:0] g;
    repeat (3) @(negedge clk_i);
    chk(synd_o == '0 && !done_o, "R1 in reset", {1'b0, done_o, synd_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(synd_o == '0 && !done_o, "R1 after reset", {1'b0, done_o, synd_o}, 0);

    for (int v = 0; v < 8; v++) run_word(VEC[v], 1'b0, "table", res);

    // R3: idle gaps with garbage bits
    run_word(VEC[7], 1'b1, "R3 gapped", res);

    // R5: generator multiples
    g = pmul(pmul(31'b100101, 31'b111101), 31'b110111);
    run_word(g, 1'b0, "R5", res);
    chk(res == '0, "R5 generator", res, 0);
    run_word(g << 5, 1'b0, "R5", res);
    chk(res == '0, "R5 shifted x5", res, 0);
    run_word(pmul(g, 31'h0000_8001), 1'b0, "R5", res);
    chk(res == '0, "R5 product", res, 0);

    // R6: single errors
    foreach (VEC[v]) begin end
    for (int t = 0; t < 3; t++) begin
      int j = (t == 0) ? 0 : (t == 1) ? 13 : 30;
      run_word(31'(1) << j, 1'b0, "R6", res);
      chk(res[4:0] == apow(j), "R6 S1 single error", res[4:0], apow(j));
      chk(res[9:5] == apow(2 * j), "R6 S2 single error", res[9:5], apow(2 * j));
    end

    // R8: outputs hold while inputs wiggle
    for (int c = 0; c < 12; c++) begin
      valid_i = c[0]; bit_i = c[1];
      @(negedge clk_i);
      chk(synd_o == res && !done_o, "R8 hold", {2'b0, synd_o}, {2'b0, res});
    end
    valid_i = 1'b0;

    // R2: start clears outputs
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(synd_o == '0, "R2 start clears", {2'b0, synd_o}, 0);

    // R2: abandon during collection
    send_bits(31'h5555_5555, 10, 1'b0);
    run_word(VEC[4], 1'b0, "R2 restart collect", res);

    // R2: abandon during evaluation
    send_bits(VEC[5], 31, 1'b0);
    repeat (20) @(negedge clk_i);
    run_word(VEC[6], 1'b0, "R2 restart eval", res);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule